// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single DMA channel. Software loads a start address, a transfer count, a mode and a mask flag through a write-only register port. Once the channel is unmasked, a device request makes the block ask the bus owner for the bus. When the bus is granted, the block runs fixed-length transfer cycles. Each cycle puts the current address on the bus and drives the memory and I/O strobes that suit the chosen transfer type.

Service ends in one of two ways: the word count runs out, or an end-of-process input arrives from outside. At that point the channel either masks itself or, when auto-reload is selected, restores its working address and count from the values software loaded. In block mode one request runs the whole service. In demand mode the bus is released whenever the request drops, and the working registers keep the progress made so far.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, hrq_o, dack_o, eop_o and all four strobes are low, and mask_o is high.
- R2: A config write loads the working value and its reload copy together. Select 0 holds the address, select 1 the count, select 2 the mode and select 3 the mask (data bit 0). The working address appears on addr_o and the working count on cur_cnt_o on the cycle after the write.
- R3: With mask_o low, a high dreq_i raises hrq_o. Neither dack_o nor any strobe goes high until hlda_i is seen high.
- R4: The write type is mode bits [1:0] = 01. During cycle states 2 and 3 it drives memw_o and ior_o high together, and it never drives memr_o or iow_o.
- R5: The read type is mode bits [1:0] = 10. During cycle states 2 and 3 it drives memr_o and iow_o high together, and it never drives memw_o or ior_o.
- R6: The verify type is mode bits [1:0] = 00. It keeps all four strobes low, still steps the address and count, and takes four clocks per transfer whatever the level of ready_i.
- R7: For the read and write types, each clock in which ready_i is low at the end of cycle state 3 adds one wait clock. During a wait clock dack_o stays high and the strobes stay high.
- R8: Each transfer moves the address by one, downward when mode bit 5 is set and upward otherwise, with wraparound. Each transfer also lowers the count by one.
- R9: The transfer in which the count steps from 0 to all-ones is the last. A count of N therefore gives N+1 transfers. eop_o is high for one clock, in state 4 of that transfer, and hrq_o and dack_o drop on the next clock.
- R10: If eop_i goes high during a transfer, the current transfer completes and service ends with it. If eop_i goes high while no transfer is running, it has no effect.
- R11: When mode bit 4 is clear, the end of service sets mask_o. While mask_o is high, dreq_i does not raise hrq_o.
- R12: When mode bit 4 is set, the end of service reloads the working address and count from their reload copies and leaves mask_o low, so the same service can run again.
- R13: In demand mode (mode bit 6 set), if dreq_i is low at the end of a transfer, the bus is released and the working address and count keep their partial values. When dreq_i returns, service resumes from those values.
- R14: In block mode (mode bit 6 clear), once hold is granted, service continues to the end even if dreq_i drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 2 | Config register select |
| cfg_wdata_i | input | CFG_W | Config write data |
| dreq_i | input | 1 | Device request |
| hlda_i | input | 1 | Hold acknowledge from bus owner |
| ready_i | input | 1 | Slow-device ready; low inserts wait clocks |
| eop_i | input | 1 | External end-of-process |
| hrq_o | output | 1 | Hold request |
| dack_o | output | 1 | Device acknowledge, high during transfer cycles |
| addr_o | output | ADDR_W | Current transfer address |
| memr_o | output | 1 | Memory read strobe |
| memw_o | output | 1 | Memory write strobe |
| ior_o | output | 1 | I/O read strobe |
| iow_o | output | 1 | I/O write strobe |
| eop_o | output | 1 | End-of-service indication |
| mask_o | output | 1 | Channel mask flag |
| cur_cnt_o | output | CNT_W | Current word count |

## Verification
The properties assume three things. Software writes config registers only while hrq_o is low. The bus owner holds hlda_i high for as long as hrq_o stays high. A config write never coincides with the final clock of a transfer, because the write would take priority over that clock's register update. The stimulus keeps to these assumptions: every register write happens between services, and the acknowledge model simply copies hrq_o one half-clock later. External end-of-process pulses and ready_i waits are placed at chosen dack_o counts, so the bench can compute exactly which transfer each one affects.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10,
    XF_SPARE  = 2'b11
  } xfer_e;

  typedef struct packed {
    logic  demand;
    logic  dec;
    logic  autoinit;
    xfer_e xfer;
  } mode_t;

  localparam int unsigned AUTO_BIT   = 4;
  localparam int unsigned DEC_BIT    = 5;
  localparam int unsigned DEMAND_BIT = 6;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;
endpackage

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              step_i,
  input  logic              end_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output mode_t             mode_o,
  output logic              mask_o,
  output logic              tc_pend_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] base_addr_q, cur_addr_q, addr_next;
  logic [CNT_W-1:0]  base_cnt_q, cur_cnt_q;
  mode_t             mode_q;
  logic              mask_q;

  assign addr_next = mode_q.dec ? cur_addr_q - ADDR_ONE : cur_addr_q + ADDR_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
      base_cnt_q  <= '0;
      cur_cnt_q   <= '0;
      mode_q      <= '0;
      mask_q      <= 1'b1;
    end else if (we_i) begin
      case (sel_i)
        SEL_ADDR: begin
          base_addr_q <= wdata_i[ADDR_W-1:0];
          cur_addr_q  <= wdata_i[ADDR_W-1:0];
        end
        SEL_CNT: begin
          base_cnt_q <= wdata_i[CNT_W-1:0];
          cur_cnt_q  <= wdata_i[CNT_W-1:0];
        end
        SEL_MODE: begin
          mode_q.xfer     <= xfer_e'(wdata_i[1:0]);
          mode_q.autoinit <= wdata_i[AUTO_BIT];
          mode_q.dec      <= wdata_i[DEC_BIT];
          mode_q.demand   <= wdata_i[DEMAND_BIT];
        end
        default: mask_q <= wdata_i[0];
      endcase
    end else if (step_i) begin
      if (end_i && mode_q.autoinit) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end else begin
        cur_addr_q <= addr_next;
        cur_cnt_q  <= cur_cnt_q - CNT_ONE;
      end
      if (end_i && !mode_q.autoinit) mask_q <= 1'b1;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign mode_o     = mode_q;
  assign mask_o     = mask_q;
  assign tc_pend_o  = (cur_cnt_q == '0);
endmodule

// File: rtl/dma_seq_fsm.sv
`timescale 1ns/1ps
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dreq_i,
  input  logic       mask_i,
  input  logic       hlda_i,
  input  logic       ready_i,
  input  logic       verify_i,
  input  logic       demand_i,
  input  logic       eop_i,
  input  logic       tc_pend_i,
  output seq_state_e state_o,
  output logic       step_o,
  output logic       end_o
);
  seq_state_e state_q, state_d;
  logic       ext_q;
  logic       active, term;

  assign active = (state_q == ST_T1) || (state_q == ST_T2) ||
                  (state_q == ST_T3) || (state_q == ST_T4);
  // external end is taken live in state 4 or latched earlier in the cycle
  assign term   = tc_pend_i || ext_q || eop_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (dreq_i && !mask_i) state_d = ST_HOLD;
      ST_HOLD: if (hlda_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   if (ready_i || verify_i) state_d = ST_T4;
      ST_T4: begin
        if (term)                     state_d = ST_IDLE;
        else if (!demand_i || dreq_i) state_d = ST_T1;
        else                          state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ext_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!active || state_q == ST_T4) ext_q <= 1'b0;
      else if (eop_i)                  ext_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign step_o  = (state_q == ST_T4);
  assign end_o   = step_o && term;
endmodule

// File: rtl/dma_strobe_dec.sv
`timescale 1ns/1ps
module dma_strobe_dec
  import dma_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  xfer_e      xfer_i,
  output logic       memr_o,
  output logic       memw_o,
  output logic       ior_o,
  output logic       iow_o
);
  logic on;

  assign on     = (state_i == ST_T2) || (state_i == ST_T3);
  assign memr_o = on && (xfer_i == XF_READ);
  assign iow_o  = on && (xfer_i == XF_READ);
  assign memw_o = on && (xfer_i == XF_WRITE);
  assign ior_o  = on && (xfer_i == XF_WRITE);
endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int CNT_W  = 16,
  localparam int CFG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              dreq_i,
  input  logic              hlda_i,
  input  logic              ready_i,
  input  logic              eop_i,
  output logic              hrq_o,
  output logic              dack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              memr_o,
  output logic              memw_o,
  output logic              ior_o,
  output logic              iow_o,
  output logic              eop_o,
  output logic              mask_o,
  output logic [CNT_W-1:0]  cur_cnt_o
);
  seq_state_e state_w;
  mode_t      mode_w;
  logic       step_w, end_w, tc_pend_w, mask_w, verify_w, autoinit_w;

  assign verify_w   = !((mode_w.xfer == XF_WRITE) || (mode_w.xfer == XF_READ));
  assign autoinit_w = mode_w.autoinit;

  dma_chan_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .CFG_W  (CFG_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .step_i     (step_w),
    .end_i      (end_w),
    .cur_addr_o (addr_o),
    .cur_cnt_o  (cur_cnt_o),
    .mode_o     (mode_w),
    .mask_o     (mask_w),
    .tc_pend_o  (tc_pend_w)
  );

  dma_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dreq_i    (dreq_i),
    .mask_i    (mask_w),
    .hlda_i    (hlda_i),
    .ready_i   (ready_i),
    .verify_i  (verify_w),
    .demand_i  (mode_w.demand),
    .eop_i     (eop_i),
    .tc_pend_i (tc_pend_w),
    .state_o   (state_w),
    .step_o    (step_w),
    .end_o     (end_w)
  );

  dma_strobe_dec u_strb (
    .state_i (state_w),
    .xfer_i  (mode_w.xfer),
    .memr_o  (memr_o),
    .memw_o  (memw_o),
    .ior_o   (ior_o),
    .iow_o   (iow_o)
  );

  assign hrq_o  = (state_w != ST_IDLE);
  assign dack_o = (state_w != ST_IDLE) && (state_w != ST_HOLD);
  assign eop_o  = end_w;
  assign mask_o = mask_w;
endmodule

// File: rtl/dma_seq_chk.sv
`timescale 1ns/1ps
module dma_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_we_i,
  input logic hrq_o,
  input logic dack_o,
  input logic memr_o,
  input logic memw_o,
  input logic ior_o,
  input logic iow_o,
  input logic eop_o,
  input logic mask_o,
  input logic verify_i,
  input logic autoinit_i
);
  a_r3_dack_under_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> hrq_o);
  a_r3_strobe_in_dack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memr_o || memw_o || ior_o || iow_o) |-> dack_o);
  a_r4_write_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    memw_o |-> (ior_o && !memr_o && !iow_o));
  a_r5_read_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    memr_o |-> (iow_o && !memw_o && !ior_o));
  a_r6_verify_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verify_i |-> !(memr_o || memw_o || ior_o || iow_o));
  a_r9_end_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> (!dack_o && !hrq_o));
  a_r11_end_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_o && !autoinit_i && !cfg_we_i) |=> mask_o);
  a_r11_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o && !hrq_o && !cfg_we_i) |=> !hrq_o);
  a_r12_reload_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_o && autoinit_i && !mask_o && !cfg_we_i) |=> !mask_o);
endmodule

bind dma_xfer_seq dma_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .hrq_o      (hrq_o),
  .dack_o     (dack_o),
  .memr_o     (memr_o),
  .memw_o     (memw_o),
  .ior_o      (ior_o),
  .iow_o      (iow_o),
  .eop_o      (eop_o),
  .mask_o     (mask_o),
  .verify_i   (verify_w),
  .autoinit_i (autoinit_w)
);

// File: tb/sim_dma_xfer_seq.sv
`timescale 1ns/1ps
module sim_dma_xfer_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = 2'd0;
  logic [15:0] cfg_wdata_i = 16'd0;
  logic        dreq_i = 1'b0;
  logic        hlda_i = 1'b0;
  logic        ready_i = 1'b1;
  logic        eop_i = 1'b0;
  logic        hrq_o, dack_o, memr_o, memw_o, ior_o, iow_o, eop_o, mask_o;
  logic [15:0] addr_o, cur_cnt_o;

  int n_chk = 0;
  int n_err = 0;
  bit hlda_en = 1'b1;
  int c_dack = 0, c_memr = 0, c_memw = 0, c_ior = 0, c_iow = 0, c_eop = 0;
  int s_dack, s_memr, s_memw, s_ior, s_iow, s_eop;

  localparam logic [15:0] M_VERIFY = 16'h0000;
  localparam logic [15:0] M_WRITE  = 16'h0001;
  localparam logic [15:0] M_READ   = 16'h0002;
  localparam logic [15:0] M_AUTO   = 16'h0010;
  localparam logic [15:0] M_DEC    = 16'h0020;
  localparam logic [15:0] M_DEMAND = 16'h0040;

  dma_xfer_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .dreq_i(dreq_i), .hlda_i(hlda_i), .ready_i(ready_i),
    .eop_i(eop_i), .hrq_o(hrq_o), .dack_o(dack_o), .addr_o(addr_o), .memr_o(memr_o),
    .memw_o(memw_o), .ior_o(ior_o), .iow_o(iow_o), .eop_o(eop_o), .mask_o(mask_o),
    .cur_cnt_o(cur_cnt_o)
  );

  initial forever #2.5 clk_i = ~clk_i;

  // monitor and bus-owner model, both at the falling edge
  initial forever begin
    @(negedge clk_i);
    if (dack_o) c_dack++;
    if (memr_o) c_memr++;
    if (memw_o) c_memw++;
    if (ior_o)  c_ior++;
    if (iow_o)  c_iow++;
    if (eop_o)  c_eop++;
    hlda_i = hlda_en && hrq_o;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  task automatic snap();
    s_dack = c_dack; s_memr = c_memr; s_memw = c_memw;
    s_ior = c_ior; s_iow = c_iow; s_eop = c_eop;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
    tick();
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic program_ch(input logic [15:0] mode, input logic [15:0] adr, input logic [15:0] cnt);
    cfg_write(2'd2, mode);
    cfg_write(2'd0, adr);
    cfg_write(2'd1, cnt);
    cfg_write(2'd3, 16'h0000);
  endtask

  task automatic wait_hrq(input string tag);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (hrq_o) return;
    end
    chk(tag, "hrq rise timeout", 0, 1);
  endtask

  task automatic start_block(input string tag);
    dreq_i = 1'b1;
    wait_hrq(tag);
    dreq_i = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (!hrq_o) return;
    end
    chk(tag, "service end timeout", 0, 1);
  endtask

  task automatic t_reset();
    chk("R1", "hrq", hrq_o, 0);
    chk("R1", "dack", dack_o, 0);
    chk("R1", "strobes", {memr_o, memw_o, ior_o, iow_o}, 0);
    chk("R1", "eop", eop_o, 0);
    chk("R1", "mask", mask_o, 1);
  endtask

  task automatic t_load();
    cfg_write(2'd0, 16'h1234);
    cfg_write(2'd1, 16'h0005);
    chk("R2", "addr", addr_o, 16'h1234);
    chk("R2", "count", cur_cnt_o, 16'h0005);
  endtask

  // R3 and R4: hold gating, then one write transfer to terminal count
  task automatic t_hold_write();
    program_ch(M_WRITE, 16'h0100, 16'h0000);
    hlda_en = 1'b0;
    snap();
    dreq_i = 1'b1;
    repeat (6) tick();
    chk("R3", "hrq while waiting", hrq_o, 1);
    chk("R3", "dack before grant", c_dack - s_dack, 0);
    chk("R3", "memw before grant", c_memw - s_memw, 0);
    dreq_i = 1'b0;
    hlda_en = 1'b1;
    wait_idle("R3");
    chk("R4", "dack clocks", c_dack - s_dack, 4);
    chk("R4", "memw clocks", c_memw - s_memw, 2);
    chk("R4", "ior clocks", c_ior - s_ior, 2);
    chk("R4", "memr+iow clocks", (c_memr - s_memr) + (c_iow - s_iow), 0);
    chk("R8", "addr up", addr_o, 16'h0101);
    chk("R9", "count wrap", cur_cnt_o, 16'hFFFF);
    chk("R9", "eop pulses", c_eop - s_eop, 1);
    chk("R11", "mask after end", mask_o, 1);
  endtask

  // R5, R7, R14: read with four-clock state 3 on the first transfer
  task automatic t_read_ready();
    program_ch(M_READ, 16'h0200, 16'h0001);
    ready_i = 1'b0;
    snap();
    start_block("R14");
    for (int i = 0; i < 20 && !memr_o; i++) tick();
    repeat (4) tick();
    ready_i = 1'b1;
    wait_idle("R7");
    chk("R7", "dack clocks with waits", c_dack - s_dack, 11);
    chk("R7", "memr clocks", c_memr - s_memr, 7);
    chk("R5", "iow clocks", c_iow - s_iow, 7);
    chk("R5", "memw+ior clocks", (c_memw - s_memw) + (c_ior - s_ior), 0);
    chk("R14", "addr after block", addr_o, 16'h0202);
    chk("R9", "count after block", cur_cnt_o, 16'hFFFF);
  endtask

  // R6 and R8: verify, counting down through zero, ready held low
  task automatic t_verify_dec();
    program_ch(M_VERIFY | M_DEC, 16'h0001, 16'h0002);
    ready_i = 1'b0;
    snap();
    start_block("R6");
    wait_idle("R6");
    ready_i = 1'b1;
    chk("R6", "dack clocks", c_dack - s_dack, 12);
    chk("R6", "strobe clocks",
        (c_memr - s_memr) + (c_memw - s_memw) + (c_ior - s_ior) + (c_iow - s_iow), 0);
    chk("R8", "addr down wrap", addr_o, 16'hFFFE);
    chk("R6", "eop pulses", c_eop - s_eop, 1);
  endtask

  task automatic t_masked();
    snap();
    dreq_i = 1'b1;
    repeat (10) tick();
    chk("R11", "hrq while masked", hrq_o, 0);
    chk("R11", "dack while masked", c_dack - s_dack, 0);
    dreq_i = 1'b0;
  endtask

  // R10: external end pulse during transfer 2 state 2
  task automatic t_ext_eop();
    program_ch(M_WRITE, 16'h0300, 16'd20);
    eop_i = 1'b1;
    repeat (2) tick();
    eop_i = 1'b0;
    chk("R10", "idle pulse ignored, count", cur_cnt_o, 16'd20);
    chk("R10", "idle pulse ignored, mask", mask_o, 0);
    snap();
    start_block("R10");
    for (int i = 0; i < 40 && (c_dack - s_dack) < 6; i++) tick();
    eop_i = 1'b1;
    tick();
    eop_i = 1'b0;
    wait_idle("R10");
    chk("R10", "dack clocks", c_dack - s_dack, 8);
    chk("R10", "count left", cur_cnt_o, 16'd18);
    chk("R10", "addr", addr_o, 16'h0302);
    chk("R10", "mask", mask_o, 1);
  endtask

  // R13: demand mode, request dropped in transfer 3 state 2
  task automatic t_demand();
    program_ch(M_WRITE | M_DEMAND, 16'h0400, 16'd9);
    snap();
    dreq_i = 1'b1;
    wait_hrq("R13");
    for (int i = 0; i < 40 && (c_dack - s_dack) < 10; i++) tick();
    dreq_i = 1'b0;
    repeat (5) tick();
    chk("R13", "hrq released", hrq_o, 0);
    chk("R13", "partial count", cur_cnt_o, 16'd6);
    chk("R13", "partial addr", addr_o, 16'h0403);
    chk("R13", "mask still clear", mask_o, 0);
    snap();
    dreq_i = 1'b1;
    wait_hrq("R13");
    wait_idle("R13");
    dreq_i = 1'b0;
    chk("R13", "resumed dack clocks", c_dack - s_dack, 28);
    chk("R13", "final addr", addr_o, 16'h040A);
    chk("R13", "final count", cur_cnt_o, 16'hFFFF);
  endtask

  task automatic t_autoinit();
    program_ch(M_WRITE | M_AUTO, 16'h1000, 16'h0002);
    snap();
    start_block("R12");
    wait_idle("R12");
    chk("R12", "dack clocks run 1", c_dack - s_dack, 12);
    chk("R12", "addr reloaded", addr_o, 16'h1000);
    chk("R12", "count reloaded", cur_cnt_o, 16'h0002);
    chk("R12", "mask clear", mask_o, 0);
    chk("R12", "eop pulses", c_eop - s_eop, 1);
    snap();
    start_block("R12");
    wait_idle("R12");
    chk("R12", "dack clocks run 2", c_dack - s_dack, 12);
    chk("R12", "addr reloaded again", addr_o, 16'h1000);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_load();
    t_hold_write();
    t_read_ready();
    t_verify_dec();
    t_masked();
    t_ext_eop();
    t_demand();
    t_autoinit();
    repeat (3) tick();
    summary();
    $finish;
  end
endmodule